// File: doc/BRIEF.md
# Alarm Status and Interrupt Controller

This block keeps one status bit per receive alarm and drives one interrupt line to a host processor. The status bits follow their alarm conditions and are not latched. One bit comes straight from a raw carrier-loss input pin. Three bits take level signals produced elsewhere: two persistence detectors (line alarm indication and far-end receive failure) and a receive FIFO overflow monitor. The interrupt is raised whenever any status bit changes, in either direction. It is dropped when the host reads any address inside the status window.

The host reads through a strobe-and-address port. A strobe lasts one cycle and comes with an address. The selected word appears on the read data port after the next clock edge. Reading never changes a status bit, so the host always sees the live state of every condition. The carrier-loss bit ignores both resets. The other bits, and the interrupt, are cleared by the synchronous hardware reset and by a one-cycle software reset pulse.

Top module: `alarm_irq_top`

## Requirements
- R1: Status bit 0 (carrier loss) equals the carrier-loss pin as sampled at the read edge. Neither the hardware reset nor the software reset changes it.
- R2: Status bits 1, 2 and 3 take level inputs 0, 1 and 2 (line alarm indication, far-end receive failure, FIFO overflow) one clock after those inputs change.
- R3: When a status bit rises, the interrupt output (active high) goes high on the clock edge that follows the change.
- R4: When a status bit falls, the interrupt output also goes high on the clock edge that follows the change.
- R5: A read strobe at any address from STAT_BASE to STAT_BASE+STAT_COUNT-1 drives the interrupt low at that edge, as long as no status bit changes in the same cycle.
- R6: A read leaves every status bit unchanged. A second read returns the same word while the conditions are held.
- R7: If a status bit changes in the same cycle as a read inside the window, the interrupt stays high.
- R8: The hardware reset (rstN low) and the software reset pulse (swReset high) clear status bits 1 to 3 and the interrupt. The reset itself raises no interrupt.
- R9: A read strobe at an address outside the window returns 0x00 and leaves the interrupt as it was.
- R10: The read data is registered and loaded on every strobe. At address STAT_BASE it holds the status bits in bits 3:0, with bits 7:4 zero. The other addresses of the window read as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous hardware reset, active low |
| swReset | input | 1 | Software reset pulse, active high |
| carrierLossPin | input | 1 | Raw carrier-loss condition |
| lvlAlarms | input | NUM_LVL | Level alarms: [0] line alarm indication, [1] far-end receive failure, [2] FIFO overflow |
| rdStrobe | input | 1 | Single-cycle read strobe |
| rdAddr | input | ADDR_W | Read address |
| rdData | output | DATA_W | Registered read data |
| irq | output | 1 | Interrupt, active high |

## Verification
The hardest case to reach from the ports is a status change that falls in the same cycle as a clearing read. The stimulus first raises the interrupt with one level alarm. It then changes a second level alarm, waits exactly one edge so that the registered status bit flips, and issues the read on the next edge. The interrupt must still be high after that read, and only a second read may clear it. The reset cases are also timed with care. Reads are issued while the hardware reset is held and on the cycle just after a software reset pulse. This shows that the carrier-loss bit still tracks its pin while the other bits read as zero, and that no interrupt comes from the reset itself.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;

  // Strobes sent from the control unit to the datapath each cycle
  typedef struct packed {
    logic loadRd;        // capture a new read word this cycle
    logic selAlarmWord;  // the captured word is the alarm status word
    logic clrAlarms;     // software reset of the resettable status bits
  } ctlStrobes_t;

endpackage

// File: rtl/alarm_irq_datapath.sv
module alarm_irq_datapath
  import alarm_irq_pkg::*;
#(
  parameter int NUM_LVL = 3,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               carrierLossPin,
  input  logic [NUM_LVL-1:0] lvlAlarms,
  input  ctlStrobes_t        ctl,
  output logic [DATA_W-1:0]  rdData,
  output logic               anyChange
);

  localparam int NUM_BITS = NUM_LVL + 1;
  localparam int PAD_W    = DATA_W - NUM_BITS;

  logic [NUM_LVL-1:0]  lvlQ;
  logic [NUM_BITS-1:0] statusNow;
  logic [NUM_BITS-1:0] prevQ;
  logic                clrLvl;

  assign clrLvl = !rstN || ctl.clrAlarms;

  // One resettable status flop per level alarm
  for (genvar i = 0; i < NUM_LVL; i++) begin : g_lvl
    logic bitQ;
    always_ff @(posedge clk) begin
      if (clrLvl) bitQ <= 1'b0;
      else        bitQ <= lvlAlarms[i];
    end
    assign lvlQ[i] = bitQ;
  end

  // The carrier-loss bit is the pin itself, so no reset can reach it
  assign statusNow = {lvlQ, carrierLossPin};

  // Registered copy of the status bits, used to detect changes
  always_ff @(posedge clk) begin
    if (clrLvl) prevQ <= {{NUM_LVL{1'b0}}, carrierLossPin};
    else        prevQ <= statusNow;
  end

  assign anyChange = |(statusNow ^ prevQ);

  // Read word register, loaded on every strobe
  always_ff @(posedge clk) begin
    if (ctl.loadRd) begin
      if (ctl.selAlarmWord) rdData <= {{PAD_W{1'b0}}, statusNow};
      else                  rdData <= '0;
    end
  end

  AST_LVL_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN || ctl.clrAlarms)
    1'b1 |=> lvlQ == $past(lvlAlarms)); // R2
  AST_RESET_CLEARS_LVL: assert property (@(posedge clk)
    (!rstN || ctl.clrAlarms) |=> lvlQ == '0); // R8
  AST_LOC_IN_WORD: assert property (@(posedge clk)
    (ctl.loadRd && ctl.selAlarmWord) |=> rdData[0] == $past(carrierLossPin)); // R1
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadRd |=> rdData[DATA_W-1:NUM_BITS] == '0); // R10

endmodule

// File: rtl/alarm_irq_ctrl.sv
module alarm_irq_ctrl
  import alarm_irq_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int STAT_BASE  = 2,
  parameter int STAT_COUNT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              swReset,
  input  logic              rdStrobe,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              anyChange,
  output ctlStrobes_t       ctl,
  output logic              irq
);

  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(STAT_BASE);
  localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(STAT_BASE + STAT_COUNT - 1);

  logic inWindow;
  logic rdHit;

  assign inWindow = (rdAddr >= BASE_A) && (rdAddr <= LAST_A);
  assign rdHit    = rdStrobe && inWindow;

  always_comb begin
    ctl.loadRd       = rdStrobe;
    ctl.selAlarmWord = rdHit && (rdAddr == BASE_A);
    ctl.clrAlarms    = swReset;
  end

  // A change wins over a clearing read, so no event is lost
  always_ff @(posedge clk) begin
    if (!rstN || swReset) irq <= 1'b0;
    else if (anyChange)   irq <= 1'b1;
    else if (rdHit)       irq <= 1'b0;
  end

  AST_IRQ_ON_CHANGE: assert property (@(posedge clk) disable iff (!rstN || swReset)
    anyChange |=> irq); // R3 R4 R7
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN || swReset)
    (rdHit && !anyChange) |=> !irq); // R5
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(anyChange)); // R3
  AST_RESET_IRQ: assert property (@(posedge clk)
    (!rstN || swReset) |=> !irq); // R8
  AST_OUTSIDE_KEEPS: assert property (@(posedge clk) disable iff (!rstN || swReset)
    (rdStrobe && !inWindow && irq) |=> irq); // R9

endmodule

// File: rtl/alarm_irq_top.sv
module alarm_irq_top
  import alarm_irq_pkg::*;
#(
  parameter int NUM_LVL    = 3,
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 4,
  parameter int STAT_BASE  = 2,
  parameter int STAT_COUNT = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               swReset,
  input  logic               carrierLossPin,
  input  logic [NUM_LVL-1:0] lvlAlarms,
  input  logic               rdStrobe,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic [DATA_W-1:0]  rdData,
  output logic               irq
);

  ctlStrobes_t ctl;
  logic        anyChange;

  alarm_irq_ctrl #(
    .ADDR_W    (ADDR_W),
    .STAT_BASE (STAT_BASE),
    .STAT_COUNT(STAT_COUNT)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .swReset  (swReset),
    .rdStrobe (rdStrobe),
    .rdAddr   (rdAddr),
    .anyChange(anyChange),
    .ctl      (ctl),
    .irq      (irq)
  );

  alarm_irq_datapath #(
    .NUM_LVL(NUM_LVL),
    .DATA_W (DATA_W)
  ) dp_i (
    .clk           (clk),
    .rstN          (rstN),
    .carrierLossPin(carrierLossPin),
    .lvlAlarms     (lvlAlarms),
    .ctl           (ctl),
    .rdData        (rdData),
    .anyChange     (anyChange)
  );

endmodule

// File: tb/alarm_irq_tb.sv
module alarm_irq_top_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       swReset = 1'b0;
  logic       carrierLossPin = 1'b0;
  logic [2:0] lvlAlarms = 3'b000;
  logic       rdStrobe = 1'b0;
  logic [3:0] rdAddr = 4'd0;
  logic [7:0] rdData;
  logic       irq;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;
  bit summaryOut = 1'b0;

  logic [7:0] expQ[$];
  string      tagQ[$];
  logic       rdSeen = 1'b0;

  always #5 clk = ~clk;

  alarm_irq_top dut_i (
    .clk(clk), .rstN(rstN), .swReset(swReset), .carrierLossPin(carrierLossPin),
    .lvlAlarms(lvlAlarms), .rdStrobe(rdStrobe), .rdAddr(rdAddr),
    .rdData(rdData), .irq(irq)
  );

  // Monitor: compares each read word with the scoreboard queue
  always @(posedge clk) rdSeen <= rdStrobe;

  always @(negedge clk) begin
    if (rdSeen) begin
      logic [7:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      nChecks++;
      if (rdData !== e) begin
        nFails++;
        $display("FAIL %s: rdData actual %02h expected %02h", t, rdData, e);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver: one read strobe, expected word pushed to the scoreboard
  task automatic doRead(logic [3:0] a, logic [7:0] e, string t);
    rdStrobe = 1'b1;
    rdAddr   = a;
    expQ.push_back(e);
    tagQ.push_back(t);
    @(negedge clk);
    rdStrobe = 1'b0;
  endtask

  task automatic chkIrq(logic e, string t);
    nChecks++;
    if (irq !== e) begin
      nFails++;
      $display("FAIL %s: irq actual %b expected %b", t, irq, e);
    end
  endtask

  task automatic summary();
    if (!summaryOut) begin
      summaryOut = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tick(2);
    chkIrq(1'b0, "R8 irq low in hw reset");
    carrierLossPin = 1'b1;
    doRead(4'd2, 8'h01, "R1 pin seen while hw reset held");
    tick(1);
    rstN = 1'b1;
    tick(3);
    chkIrq(1'b0, "R8 R1 no interrupt from reset release");

    lvlAlarms = 3'b001;
    tick(1);
    chkIrq(1'b0, "R3 not before status edge");
    tick(1);
    chkIrq(1'b1, "R3 rise of line alarm bit");
    doRead(4'd2, 8'h03, "R10 R2 status word");
    chkIrq(1'b0, "R5 read clears irq");
    doRead(4'd2, 8'h03, "R6 bits kept after read");

    lvlAlarms = 3'b000;
    tick(2);
    chkIrq(1'b1, "R4 fall of line alarm bit");
    doRead(4'd2, 8'h01, "R2 bit cleared with input");
    chkIrq(1'b0, "R5 read clears irq");

    carrierLossPin = 1'b0;
    tick(1);
    chkIrq(1'b1, "R1 R4 carrier pin fall");
    doRead(4'd0, 8'h00, "R9 outside window reads zero");
    chkIrq(1'b1, "R9 outside read keeps irq");
    doRead(4'd3, 8'h00, "R10 alias word reads zero");
    chkIrq(1'b0, "R5 alias address clears irq");

    lvlAlarms = 3'b010;
    tick(2);
    chkIrq(1'b1, "R3 far-end bit rise");
    lvlAlarms = 3'b110;
    tick(1);
    doRead(4'd2, 8'h0C, "R7 word at colliding read");
    chkIrq(1'b1, "R7 change wins over read");
    doRead(4'd2, 8'h0C, "R6 word stable");
    chkIrq(1'b0, "R5 second read clears");

    carrierLossPin = 1'b1;
    tick(1);
    chkIrq(1'b1, "R3 carrier pin rise");
    swReset = 1'b1;
    tick(1);
    swReset = 1'b0;
    chkIrq(1'b0, "R8 sw reset clears irq");
    doRead(4'd2, 8'h01, "R8 R1 sw reset clears bits, keeps carrier");
    chkIrq(1'b0, "R8 no interrupt from sw reset");
    tick(1);
    chkIrq(1'b1, "R3 bits return after sw reset");
    doRead(4'd2, 8'h0D, "R2 full word");

    rstN = 1'b0;
    tick(2);
    chkIrq(1'b0, "R8 hw reset clears irq");
    carrierLossPin = 1'b0;
    doRead(4'd2, 8'h00, "R1 R8 carrier follows pin in reset, others clear");
    rstN = 1'b1;
    tick(2);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule